// File: doc/BRIEF.md
# Secure Real-Time Counter with Seconds Alarm

This block keeps wall-clock time for a chip that also runs from a slow always-on clock. A 47-bit count advances once per strobe of the 32.768 kHz low-power clock. The upper 32 bits hold whole seconds and the lower 15 bits hold the sub-second fraction, which wraps once per second. Software reaches the counter, a seconds alarm, a control word, sticky status flags and an interrupt mask through a simple word-addressed register port. The write-synchronising logic of the slow domain and the tamper monitors are outside the block. They appear only as a hold input and a "time no longer trusted" event input.

The count stops in four cases: its enable is clear, it has overflowed, the time is marked untrusted, or an external failure hold is asserted. It does not restart on its own. After an overflow, software must acknowledge the overflow flag. After the time is marked untrusted, software must clear the flag and then write a fresh seconds value. The alarm is compared only at whole-second boundaries, so one match raises the alarm flag exactly once. An alarm value of all ones means that no alarm is set.

Top module: `rtc_secure_counter`

## Requirements
- R1: After reset the seconds and fraction are zero, the control and interrupt-enable words are zero, and the alarm seconds is 0xFFFFFFFF. The status word reads 0x2, meaning only the untrusted flag is set, and the interrupt output is low.
- R2: While running, each low-power strobe adds one to the combined 47-bit time. When the fraction steps from 0x7FFF it goes to zero and the seconds value increases by one.
- R3: Control bit 3 enables counting. While it is 0, strobes leave the time unchanged.
- R4: Status bit 1 is the untrusted flag. It is set at reset and by a pulse on `nv_event_i`, and the count stays stopped while it is set. Once the flag is cleared, counting waits until software writes the seconds register.
- R5: While `hold_i` is high, strobes leave the time unchanged.
- R6: A strobe taken at the all-ones time wraps the time to zero and sets overflow flag status bit 2. The count then stays stopped until that flag is cleared.
- R7: A write to the seconds register loads the seconds and leaves the fraction as it was. A write to the fraction register loads only the fraction. A time write that coincides with a strobe wins, and that strobe is dropped.
- R8: When the fraction wraps to zero and the new seconds value equals the alarm seconds, alarm flag status bit 4 is set.
- R9: An alarm seconds value of 0xFFFFFFFF never sets the alarm flag.
- R10: The alarm fraction register always reads zero, and writes to it have no effect.
- R11: Writing 1 to a status bit clears that bit. Writing 0 leaves it unchanged. If a flag is being set and cleared in the same cycle, the set wins.
- R12: `alarm_irq_o` is high exactly when the alarm flag and interrupt-enable bit 4 are both set.
- R13: Word addresses are: 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status, 6 interrupt enable. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_tick_i | input | 1 | One-cycle strobe per low-power clock period |
| hold_i | input | 1 | External failure hold; stops the count |
| nv_event_i | input | 1 | Marks the time untrusted |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
The bench targets the restart rules after each kind of stop. A design that restarts as soon as the untrusted flag is cleared would show a moving fraction before any seconds write. A design that wraps silently at all ones would keep counting past zero with no overflow flag. The bench also targets the collisions:
- A strobe in the same cycle as a time write. A design that lets the strobe win would read back one count too high.
- An alarm match in the same cycle as a write-1 clear. A design where the clear wins would lose the alarm.

Finally, the bench places an alarm at the all-ones seconds value. A design that treats that value as a real time would raise a spurious alarm.

// File: rtl/rtc_pkg.sv
// Shared constants for the secure real-time counter: register word
// addresses and the bit positions that software decodes.
package rtc_pkg;

    localparam int SEC_W_DEF  = 32;
    localparam int FRAC_W_DEF = 15;

    typedef enum logic [3:0] {
        A_SEC      = 4'd0,
        A_FRAC     = 4'd1,
        A_ALM_SEC  = 4'd2,
        A_ALM_FRAC = 4'd3,
        A_CTRL     = 4'd4,
        A_STAT     = 4'd5,
        A_IE       = 4'd6
    } reg_addr_e;

    localparam int CTL_EN_BIT  = 3;
    localparam int ST_NV_BIT   = 1;
    localparam int ST_OVF_BIT  = 2;
    localparam int ST_ALM_BIT  = 4;
    localparam int IE_ALM_BIT  = 4;

endpackage

// File: rtl/rtc_time_counter.sv
// Combined seconds/fraction counter.
// Advances by one on `step`, loads either field from `wdata`.
// Assumes the caller never asserts step together with a load, and SEC_W <= DATA_W.
module rtc_time_counter #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              ld_sec,
    input  logic              ld_frac,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEC_W-1:0]  sec_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [SEC_W-1:0]  sec_next_o,
    output logic              boundary_o,
    output logic              carry_o
);
    localparam int TOT_W = SEC_W + FRAC_W;

    logic [SEC_W-1:0]  sec_q;
    logic [FRAC_W-1:0] frac_q;
    logic [TOT_W:0]    sum;

    // Incremented value with carry-out of the full width.
    always_comb begin
        sum = {1'b0, sec_q, frac_q} + {{TOT_W{1'b0}}, 1'b1};
    end

    assign sec_next_o = sum[TOT_W-1:FRAC_W];
    assign boundary_o = step & (&frac_q);
    assign carry_o    = step & sum[TOT_W];
    assign sec_o      = sec_q;
    assign frac_o     = frac_q;

    // Time state: field loads or single-count advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            frac_q <= '0;
        end else begin
            if (ld_sec)
                sec_q <= wdata[SEC_W-1:0];
            if (ld_frac)
                frac_q <= wdata[FRAC_W-1:0];
            if (step)
                {sec_q, frac_q} <= sum[TOT_W-1:0];
        end
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Seconds alarm register and its compare.
// A hit is reported only at a second boundary, when the new seconds equal the
// stored value. The all-ones value means that no alarm is set.
module rtc_alarm_match #(
    parameter int SEC_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] wdata,
    input  logic              boundary,
    input  logic [SEC_W-1:0]  sec_next,
    output logic [SEC_W-1:0]  alarm_o,
    output logic              hit_o
);
    localparam logic [SEC_W-1:0] UNSET = {SEC_W{1'b1}};

    logic [SEC_W-1:0] alarm_q;

    // Alarm value register, parked at the unset code after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_q <= UNSET;
        else if (ld)
            alarm_q <= wdata[SEC_W-1:0];
    end

    // Boundary-qualified compare.
    always_comb begin
        hit_o = boundary && (sec_next == alarm_q) && (alarm_q != UNSET);
    end

    assign alarm_o = alarm_q;
endmodule

// File: rtl/rtc_secure_counter.sv
// Top level of the secure real-time counter.
// Decodes register writes, keeps the control, mask and sticky status flags,
// derives the run condition and drives the read mux and the alarm interrupt.
// Assumes lp_tick_i is already a single-cycle strobe in the clk domain.
module rtc_secure_counter
    import rtc_pkg::*;
#(
    parameter int SEC_W  = SEC_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_tick_i,
    input  logic              hold_i,
    input  logic              nv_event_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              alarm_irq_o
);
    logic wr_sec, wr_frac, wr_alm, wr_ctrl, wr_stat, wr_ie;
    logic ctrl_en_q, ie_alm_q, nv_q, ovf_q, caf_q, armed_q;
    logic run, step, boundary, carry, hit;
    logic [SEC_W-1:0]  sec_cnt, sec_next, alarm_sec;
    logic [FRAC_W-1:0] frac_cnt;
    logic [DATA_W-1:0] clr_mask;

    // Write decode per register.
    always_comb begin
        wr_sec  = bus_wr_i && (bus_addr_i == ADDR_W'(A_SEC));
        wr_frac = bus_wr_i && (bus_addr_i == ADDR_W'(A_FRAC));
        wr_alm  = bus_wr_i && (bus_addr_i == ADDR_W'(A_ALM_SEC));
        wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_W'(A_CTRL));
        wr_stat = bus_wr_i && (bus_addr_i == ADDR_W'(A_STAT));
        wr_ie   = bus_wr_i && (bus_addr_i == ADDR_W'(A_IE));
    end

    // Run condition and the gated count step (a time write drops the strobe).
    always_comb begin
        run  = ctrl_en_q && !ovf_q && !nv_q && armed_q && !hold_i;
        step = lp_tick_i && run && !wr_sec && !wr_frac;
    end

    rtc_time_counter #(
        .SEC_W  (SEC_W),
        .FRAC_W (FRAC_W),
        .DATA_W (DATA_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .ld_sec     (wr_sec),
        .ld_frac    (wr_frac),
        .wdata      (bus_wdata_i),
        .sec_o      (sec_cnt),
        .frac_o     (frac_cnt),
        .sec_next_o (sec_next),
        .boundary_o (boundary),
        .carry_o    (carry)
    );

    rtc_alarm_match #(
        .SEC_W  (SEC_W),
        .DATA_W (DATA_W)
    ) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (wr_alm),
        .wdata    (bus_wdata_i),
        .boundary (boundary),
        .sec_next (sec_next),
        .alarm_o  (alarm_sec),
        .hit_o    (hit)
    );

    // Control enable and alarm mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q <= 1'b0;
            ie_alm_q  <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_en_q <= bus_wdata_i[CTL_EN_BIT];
            if (wr_ie)
                ie_alm_q <= bus_wdata_i[IE_ALM_BIT];
        end
    end

    // Write-one-to-clear mask from a status write.
    always_comb begin
        clr_mask = wr_stat ? bus_wdata_i : '0;
    end

    // Sticky flags (set wins over clear) and the "time loaded" qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_q    <= 1'b1;
            ovf_q   <= 1'b0;
            caf_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            nv_q  <= (nv_q  && !clr_mask[ST_NV_BIT])  || nv_event_i;
            ovf_q <= (ovf_q && !clr_mask[ST_OVF_BIT]) || carry;
            caf_q <= (caf_q && !clr_mask[ST_ALM_BIT]) || hit;
            if (nv_event_i)
                armed_q <= 1'b0;
            else if (wr_sec)
                armed_q <= 1'b1;
        end
    end

    // Read mux; unmapped words and the alarm fraction read zero.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(A_SEC):     bus_rdata_o[SEC_W-1:0]  = sec_cnt;
            ADDR_W'(A_FRAC):    bus_rdata_o[FRAC_W-1:0] = frac_cnt;
            ADDR_W'(A_ALM_SEC): bus_rdata_o[SEC_W-1:0]  = alarm_sec;
            ADDR_W'(A_CTRL):    bus_rdata_o[CTL_EN_BIT] = ctrl_en_q;
            ADDR_W'(A_STAT): begin
                bus_rdata_o[ST_NV_BIT]  = nv_q;
                bus_rdata_o[ST_OVF_BIT] = ovf_q;
                bus_rdata_o[ST_ALM_BIT] = caf_q;
            end
            ADDR_W'(A_IE):      bus_rdata_o[IE_ALM_BIT] = ie_alm_q;
            default:            bus_rdata_o = '0;
        endcase
    end

    // Alarm interrupt.
    assign alarm_irq_o = caf_q && ie_alm_q;
endmodule

// File: rtl/rtc_secure_counter_checker.sv
// Temporal checks on the secure real-time counter, attached by bind.
// Observes internal state only; drives nothing.
module rtc_secure_counter_checker #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_i,
    input logic              wr_time,
    input logic              ctrl_en,
    input logic              nv_flag,
    input logic              ovf_flag,
    input logic              alm_flag,
    input logic [SEC_W-1:0]  sec,
    input logic [FRAC_W-1:0] frac,
    input logic [SEC_W-1:0]  alarm_sec
);
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !wr_time) |=> ($stable(sec) && $stable(frac))); // R3

    AST_NONVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_flag && !wr_time) |=> ($stable(sec) && $stable(frac))); // R4

    AST_HOLD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !wr_time) |=> ($stable(sec) && $stable(frac))); // R5

    AST_OVERFLOW_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (sec == '0 && frac == '0)); // R6

    AST_ALARM_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> (frac == '0 && sec == $past(alarm_sec))); // R8

    AST_ALARM_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> ($past(alarm_sec) != {SEC_W{1'b1}})); // R9
endmodule

bind rtc_secure_counter rtc_secure_counter_checker #(
    .SEC_W  (SEC_W),
    .FRAC_W (FRAC_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (hold_i),
    .wr_time   (wr_sec | wr_frac),
    .ctrl_en   (ctrl_en_q),
    .nv_flag   (nv_q),
    .ovf_flag  (ovf_q),
    .alm_flag  (caf_q),
    .sec       (sec_cnt),
    .frac      (frac_cnt),
    .alarm_sec (alarm_sec)
);

// File: tb/rtc_secure_counter_bench.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model is stepped on every clock, and the
// read data at the current address plus the interrupt are compared each cycle.
// Directed scenarios add named checks with hand-computed values.
module rtc_secure_counter_bench;
    localparam longint unsigned TMAX  = (64'd1 << 47) - 1;
    localparam longint unsigned UNSET = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lp_tick = 1'b0;
    logic        hold = 1'b0;
    logic        nv_event = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int n_chk = 0;
    int n_fail = 0;

    rtc_secure_counter u_rtc_secure_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .lp_tick_i   (lp_tick),
        .hold_i      (hold),
        .nv_event_i  (nv_event),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .alarm_irq_o (alarm_irq)
    );

    always #2.5 clk = ~clk;

    // Reference model state
    longint unsigned m_time, m_alarm;
    bit m_en, m_ie, m_nv, m_ovf, m_caf, m_armed;
    bit t_wsec, t_wfrac, t_step, t_ovf_set, t_caf_set;
    logic [31:0] t_clr;

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return 32'(m_time >> 15);
            4'd1: return 32'(m_time & 64'h7FFF);
            4'd2: return 32'(m_alarm);
            4'd4: return {28'd0, m_en, 3'd0};
            4'd5: return {27'd0, m_caf, 1'b0, m_ovf, m_nv, 1'b0};
            4'd6: return {27'd0, m_ie, 4'd0};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd1: return "R2";
            4'd2: return "R8";
            4'd3: return "R10";
            4'd4: return "R3";
            4'd5: return "R11";
            4'd6: return "R12";
            default: return "R13";
        endcase
    endfunction

    // Model step on each edge, then a per-cycle comparison.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = 0; m_alarm = UNSET; m_en = 0; m_ie = 0;
            m_nv = 1; m_ovf = 0; m_caf = 0; m_armed = 0;
        end else begin
            t_wsec  = bus_wr && bus_addr == 4'd0;
            t_wfrac = bus_wr && bus_addr == 4'd1;
            t_step  = lp_tick && m_en && !m_ovf && !m_nv && m_armed && !hold
                      && !t_wsec && !t_wfrac;
            t_ovf_set = 0;
            t_caf_set = 0;
            if (t_step) begin
                if (m_time == TMAX) begin
                    m_time = 0;
                    t_ovf_set = 1;
                end else begin
                    m_time = m_time + 1;
                end
                if ((m_time & 64'h7FFF) == 0 && (m_time >> 15) == m_alarm && m_alarm != UNSET)
                    t_caf_set = 1;
            end
            if (t_wsec)
                m_time = (longint'(bus_wdata) << 15) | (m_time & 64'h7FFF);
            if (t_wfrac)
                m_time = (m_time & ~64'h7FFF) | (longint'(bus_wdata) & 64'h7FFF);
            if (bus_wr && bus_addr == 4'd2) m_alarm = longint'(bus_wdata);
            if (bus_wr && bus_addr == 4'd4) m_en = bus_wdata[3];
            if (bus_wr && bus_addr == 4'd6) m_ie = bus_wdata[4];
            t_clr = (bus_wr && bus_addr == 4'd5) ? bus_wdata : 32'd0;
            m_nv  = (m_nv  && !t_clr[1]) || nv_event;
            m_ovf = (m_ovf && !t_clr[2]) || t_ovf_set;
            m_caf = (m_caf && !t_clr[4]) || t_caf_set;
            if (nv_event) m_armed = 0;
            else if (t_wsec) m_armed = 1;
        end
        #1;
        n_chk++;
        if (bus_rdata !== model_read(bus_addr)) begin
            n_fail++;
            $display("FAIL %s cycle compare addr %0d: actual %h expected %h",
                     req_of(bus_addr), bus_addr, bus_rdata, model_read(bus_addr));
        end
        n_chk++;
        if (alarm_irq !== (m_caf && m_ie)) begin
            n_fail++;
            $display("FAIL R12 cycle compare irq: actual %b expected %b",
                     alarm_irq, m_caf && m_ie);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        lp_tick = 1'b1;
        repeat (n) @(negedge clk);
        lp_tick = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s read addr %0d: actual %h expected %h", req, a, bus_rdata, exp);
        end
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic exp, input string req);
        n_chk++;
        if (alarm_irq !== exp) begin
            n_fail++;
            $display("FAIL %s irq: actual %b expected %b", req, alarm_irq, exp);
        end
    endtask

    // Watchdog
    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1");
        chk(4'd5, 32'h2, "R1");
        chk(4'd2, 32'hFFFF_FFFF, "R1");
        chk(4'd0, 32'd0, "R1");
        chk(4'd4, 32'd0, "R1");
        // R4 untrusted flag keeps the count stopped
        wr(4'd4, 32'h8);
        ticks(5);
        chk(4'd1, 32'd0, "R4");
        // R4 clearing the flag alone does not restart
        wr(4'd5, 32'h2);
        ticks(5);
        chk(4'd1, 32'd0, "R4");
        chk(4'd5, 32'd0, "R11");
        // R7 separate loads, R2 counting and fraction wrap
        wr(4'd1, 32'h7FFD);
        wr(4'd0, 32'd100);
        chk(4'd1, 32'h7FFD, "R7");
        ticks(2);
        chk(4'd1, 32'h7FFF, "R2");
        ticks(1);
        chk(4'd0, 32'd101, "R2");
        chk(4'd1, 32'd0, "R2");
        // R8 alarm match, R12 masking
        wr(4'd2, 32'd102);
        wr(4'd1, 32'h7FFF);
        ticks(1);
        chk(4'd5, 32'h10, "R8");
        chk_irq(1'b0, "R12");
        wr(4'd6, 32'h10);
        chk_irq(1'b1, "R12");
        // R10 alarm fraction ignored
        wr(4'd3, 32'h1234);
        chk(4'd3, 32'd0, "R10");
        // R11 write-one-to-clear
        wr(4'd5, 32'h10);
        chk(4'd5, 32'd0, "R11");
        chk_irq(1'b0, "R12");
        // R11 set wins over a same-cycle clear
        wr(4'd2, 32'd103);
        wr(4'd1, 32'h7FFF);
        lp_tick = 1'b1;
        wr(4'd5, 32'h10);
        lp_tick = 1'b0;
        chk(4'd5, 32'h10, "R11");
        wr(4'd5, 32'h10);
        // R5 external hold
        wr(4'd1, 32'd0);
        hold = 1'b1;
        ticks(4);
        hold = 1'b0;
        chk(4'd1, 32'd0, "R5");
        // R3 enable clear
        wr(4'd4, 32'd0);
        ticks(4);
        chk(4'd1, 32'd0, "R3");
        wr(4'd4, 32'h8);
        // R6 overflow wraps and stops
        wr(4'd1, 32'h7FFF);
        wr(4'd0, 32'hFFFF_FFFF);
        ticks(1);
        chk(4'd5, 32'h4, "R6");
        chk(4'd0, 32'd0, "R6");
        ticks(3);
        chk(4'd1, 32'd0, "R6");
        wr(4'd5, 32'h4);
        ticks(2);
        chk(4'd1, 32'd2, "R6");
        // R9 all-ones alarm never fires
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd0, 32'hFFFF_FFFE);
        wr(4'd1, 32'h7FFF);
        ticks(1);
        chk(4'd0, 32'hFFFF_FFFF, "R9");
        chk(4'd5, 32'd0, "R9");
        // R4 untrusted event mid-run
        nv_event = 1'b1;
        @(negedge clk);
        nv_event = 1'b0;
        chk(4'd5, 32'h2, "R4");
        wr(4'd5, 32'h2);
        ticks(3);
        chk(4'd1, 32'd0, "R4");
        wr(4'd0, 32'd5);
        ticks(2);
        chk(4'd1, 32'd2, "R4");
        // R7 a time write wins over a coincident strobe
        lp_tick = 1'b1;
        wr(4'd0, 32'd7);
        lp_tick = 1'b0;
        chk(4'd0, 32'd7, "R7");
        chk(4'd1, 32'd2, "R7");
        // R13 unmapped word
        chk(4'd9, 32'd0, "R13");
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule